// File: doc/BRIEF.md
# Serial DAC Code Receiver

This block is a three-wire serial slave that collects a conversion code for a current-output DAC and holds it in a parallel code register. The host pulls an active-low select low, clocks data bits in most-significant first on rising serial-clock edges, and then raises select. The rising edge of select moves the accumulated word into the code register. The code register drives the converter switches and changes at no other time.

All three serial pins are asynchronous to the block. A fast system clock samples them through two-flop synchronizers, and every edge is detected on the synchronized copies. The code width is a parameter, normally 16 or 14. Frames of any length are accepted, and only the most recent bits that fit the register are kept. A one-cycle strobe marks each register load. A one-cycle flag marks a frame that closed with fewer clock edges than the code width.

Top module: `dac_serial_if`

## Requirements
- R1: After reset, `code_o` is all zeros and `update_o` and `short_frame_o` are low.
- R2: While select is low, each rising serial-clock edge shifts the data bit into the shift register from the LSB end. After exactly CODE_W bits, the first bit sent lands in bit CODE_W-1 of the code.
- R3: When more than CODE_W bits are clocked in one frame, the leading extra bits are dropped and the code holds the last CODE_W bits sent.
- R4: `code_o` changes only on a rising edge of select. Serial-clock edges inside a frame leave `code_o` unchanged.
- R5: Serial-clock edges and data while select is high have no effect. A later frame with no clock edges loads the shift contents from before those edges.
- R6: With CODE_W=14 and a 16-bit word sent, the code holds the last 14 bits sent.
- R7: `update_o` goes high for exactly one system-clock cycle per rising edge of select, in the same cycle that `code_o` takes its new value.
- R8: `short_frame_o` pulses together with `update_o` when the closing frame had fewer than CODE_W serial-clock edges. The register still loads the shift contents.
- R9: The shift register keeps its contents across frames. A short frame shifts its bits onto the bits left by earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_ni | input | 1 | Serial select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| code_o | output | CODE_W | DAC code register |
| update_o | output | 1 | One-cycle pulse when code_o is loaded |
| short_frame_o | output | 1 | One-cycle pulse when the closing frame had too few bits |

## Verification
The embedded assertions watch four properties on every cycle. The code register never moves without the update strobe. The strobe never lasts two cycles. The short flag never appears without the strobe. The bit counter never passes the code width. They also check that the shift register holds still while select is high.

Only the bench scenarios can show the data path itself. They cover the MSB-first placement of bits and the dropping of leading bits in long frames. They also cover the carry-over of old bits into short frames, the 14-bit variant keeping the tail of a 16-bit word, and the ignoring of clock edges outside a frame.

// File: rtl/dsif_pkg.sv
package dsif_pkg;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned PIN_W      = 3;

  typedef struct packed {
    logic sel_n;
    logic sclk;
    logic sdata;
  } pins_t;

  // select idles high, clock and data idle low
  localparam pins_t PINS_IDLE = '{sel_n: 1'b1, sclk: 1'b0, sdata: 1'b0};
endpackage

// File: rtl/dsif_sync.sv
module dsif_sync #(
  parameter int unsigned W     = 3,
  parameter int unsigned DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  st_q[s] <= RST_VAL;
      else if (s == 0) st_q[s] <= d_i;
      else          st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[DEPTH-1];
endmodule

// File: rtl/dsif_edge.sv
module dsif_edge #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/dsif_shift.sv
module dsif_shift #(
  parameter int unsigned N     = 16,
  parameter int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [N-1:0]     word_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(N);

  logic [N-1:0]     word_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (shift_en_i) word_q <= {word_q[N-2:0], bit_i};
      if (frame_start_i)
        cnt_q <= shift_en_i ? CNT_W'(1) : '0;
      else if (shift_en_i && cnt_q != CNT_MAX)
        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign word_o = word_q;
  assign cnt_o  = cnt_q;

  a_r3_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/dac_serial_if.sv
module dac_serial_if #(
  parameter int unsigned CODE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic              update_o,
  output logic              short_frame_o
);
  import dsif_pkg::*;

  localparam int unsigned CNT_W = $clog2(CODE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(CODE_W);

  pins_t raw, syn, rise, fall;
  logic [CODE_W-1:0] word;
  logic [CNT_W-1:0]  cnt;
  logic              shift_en;
  logic [CODE_W-1:0] code_q;
  logic              update_q, short_q;

  assign raw = '{sel_n: sel_ni, sclk: sclk_i, sdata: sdata_i};

  dsif_sync #(.W(PIN_W), .DEPTH(SYNC_DEPTH), .RST_VAL(PINS_IDLE)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  dsif_edge #(.W(PIN_W), .RST_VAL(PINS_IDLE)) u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(syn), .rise_o(rise), .fall_o(fall)
  );

  assign shift_en = rise.sclk & ~syn.sel_n;

  dsif_shift #(.N(CODE_W), .CNT_W(CNT_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(fall.sel_n),
    .shift_en_i   (shift_en),
    .bit_i        (syn.sdata),
    .word_o       (word),
    .cnt_o        (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= '0;
      update_q <= 1'b0;
      short_q  <= 1'b0;
    end else begin
      update_q <= rise.sel_n;
      short_q  <= rise.sel_n && (cnt < FULL_CNT);
      if (rise.sel_n) code_q <= word;
    end
  end

  assign code_o        = code_q;
  assign update_o      = update_q;
  assign short_frame_o = short_q;

  a_r4_code_moves_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != $past(code_q)) |-> update_q);

  a_r7_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_q |=> !update_q);

  a_r8_short_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_q |-> update_q);

  a_r5_hold_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn.sel_n |=> $stable(word));
endmodule

// File: tb/dac_serial_if_tb.sv
module dac_serial_if_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sel_ni = 1'b1, sclk_i = 1'b0, sdata_i = 1'b0;
  logic [15:0] code16;
  logic [13:0] code14;
  logic upd16, upd14, sh16, sh14;

  int total = 0, bad = 0;
  int n_upd16 = 0, n_upd14 = 0, n_sh16 = 0, n_sh14 = 0;
  logic [15:0] m16 = '0;
  logic [13:0] m14 = '0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  dac_serial_if #(.CODE_W(16)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_ni(sel_ni), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .code_o(code16), .update_o(upd16), .short_frame_o(sh16)
  );

  dac_serial_if #(.CODE_W(14)) u_dut14 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_ni(sel_ni), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .code_o(code14), .update_o(upd14), .short_frame_o(sh14)
  );

  always @(negedge clk_i) begin
    if (upd16) n_upd16++;
    if (upd14) n_upd14++;
    if (sh16)  n_sh16++;
    if (sh14)  n_sh14++;
  end

  localparam int NV = 8;
  localparam int          V_NB [NV] = '{16, 16, 16, 24, 8, 16, 20, 15};
  localparam logic [31:0] V_D  [NV] = '{32'hA5C3, 32'hFFFF, 32'h0000, 32'h128001,
                                        32'h3C, 32'h8000, 32'hF7FFF, 32'h1234};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_upd16 = 0; n_upd14 = 0; n_sh16 = 0; n_sh14 = 0;
  endtask

  task automatic send_frame(input int nb, input logic [31:0] d, input string req16,
                            input string req14);
    logic [15:0] prev16;
    logic [13:0] prev14;
    prev16 = m16;
    prev14 = m14;
    clear_counts();
    @(negedge clk_i) sel_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    for (int i = nb - 1; i >= 0; i--) begin
      sdata_i = d[i];
      sclk_i  = 1'b0;
      repeat (4) @(negedge clk_i);
      sclk_i = 1'b1;
      m16 = {m16[14:0], d[i]};
      m14 = {m14[12:0], d[i]};
      repeat (4) @(negedge clk_i);
    end
    sclk_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R4 code held inside frame", 32'(code16), 32'(prev16));
    chk("R4 code14 held inside frame", 32'(code14), 32'(prev14));
    sel_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    chk(req16, 32'(code16), 32'(m16));
    chk(req14, 32'(code14), 32'(m14));
    chk("R7 one strobe", 32'(n_upd16), 32'd1);
    chk("R7 one strobe 14", 32'(n_upd14), 32'd1);
    chk("R8 short flag", 32'(n_sh16), (nb < 16) ? 32'd1 : 32'd0);
    chk("R8 short flag 14", 32'(n_sh14), (nb < 14) ? 32'd1 : 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 code reset", 32'(code16), 32'd0);
    chk("R1 code14 reset", 32'(code14), 32'd0);
    chk("R1 flags reset", {30'd0, upd16, sh16}, 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      send_frame(V_NB[v], V_D[v],
                 (V_NB[v] > 16) ? "R3 last bits kept" :
                 (V_NB[v] < 16) ? "R9 short carries old bits" : "R2 msb first",
                 (V_NB[v] >= 16) ? "R6 last 14 of word" : "R9 short carries old bits 14");
    end

    // R2: first bit of an exact frame lands in the top bit
    send_frame(16, 32'h8001, "R2 first bit to msb", "R6 tail of 16");
    chk("R2 msb set", 32'(code16[15]), 32'd1);

    // R5: clock activity with select high
    clear_counts();
    sel_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      sdata_i = i[0];
      sclk_i = 1'b1; repeat (4) @(negedge clk_i);
      sclk_i = 1'b0; repeat (4) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
    chk("R5 no strobe when deselected", 32'(n_upd16), 32'd0);
    chk("R5 code kept when deselected", 32'(code16), 32'(m16));
    send_frame(0, 32'd0, "R5 shift untouched by idle clocks", "R5 shift14 untouched");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule